// File: doc/BRIEF.md
# Dual-Mode Multiplexed Host Bus Interface

This block connects a small bank of on-chip registers to an asynchronous 8-bit microprocessor bus. Two static mode pins set how the pins are read. The strobe mode selects either a pair of separate active-low read and write strobes, or a single active-low data strobe with a read/write qualifier. The bus mode selects either a dedicated address bus, or an address that shares the data bus and is captured by an address-latch-enable pulse.

The bus-side select, strobes and address-latch-enable are brought into the internal clock domain through a short synchronizer chain. Address and data travel through the same chain, so they stay aligned with the strobes. A write takes effect when its strobe is released, using the address and data present at that moment. Read data is refreshed every cycle from the current address. The tristate enable of the data bus comes straight from the select and read pins, so the bus is released as soon as the host ends the read.

A sticky event-flag register with a mask drives an active-low, open-drain interrupt request. The output port only ever requests a pull-down and never drives the line high.

Top module: `dualmode_host_if`

## Requirements
- R1: An active-low `rst_n` acts at once, without waiting for a clock edge. It returns general register i to 0xA0 + i, clears the event flags and the mask, and releases the interrupt (`irq_pull_o` = 0).
- R2: With `strobe_mode_i` = 0, `line_b_i` is an active-low write strobe. A write to general register i (addresses 0..7) is committed when that strobe rises, using the address and data present at that time.
- R3: In both strobe modes, `bus_d_oe_o` is 1 while `cs_n_i` is low, `line_a_n_i` is low and `line_b_i` is high, and `bus_d_o` then carries the addressed register. The enable drops as soon as the strobe or the select goes high.
- R4: With `strobe_mode_i` = 1, `line_a_n_i` is an active-low data strobe and `line_b_i` is a qualifier (1 = read, 0 = write). A write commits on the rising edge of the data strobe while the qualifier is low.
- R5: With `mux_mode_i` = 1, the address is the low 4 bits of `bus_d_i` at the falling edge of `ale_i`, whatever the state of the select. It is kept for every later access until the next falling edge, and `addr_i` is ignored. With `mux_mode_i` = 0, the address comes from `addr_i`.
- R6: While `cs_n_i` is high, strobe activity writes nothing and never enables the data bus.
- R7: The data bus is never driven while `line_b_i` is low.
- R8: A 1 on bit k of `evt_i` sets sticky flag k. The flags read back at address 8, and writing 1s there clears those bits. The mask sits at address 9. `irq_pull_o` is 1 (pull the line low) exactly when some flag and its mask bit are both set; 0 means released.
- R9: Addresses 10 to 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_mode_i | input | 1 | 0: separate read/write strobes, 1: data strobe plus read/write qualifier |
| mux_mode_i | input | 1 | 1: address multiplexed on the data bus, 0: separate address bus |
| cs_n_i | input | 1 | Active-low chip select |
| ale_i | input | 1 | Address-latch-enable, used in multiplexed mode |
| line_a_n_i | input | 1 | Read strobe (separate mode) or data strobe (qualifier mode), active low |
| line_b_i | input | 1 | Write strobe, active low (separate mode), or read/write qualifier (qualifier mode) |
| addr_i | input | AW (4) | Address bus in non-multiplexed mode |
| bus_d_i | input | DW (8) | Data bus as seen at the pad input |
| bus_d_o | output | DW (8) | Read data toward the pad |
| bus_d_oe_o | output | 1 | Pad output enable for the data bus |
| evt_i | input | NEV (8) | Internal event pulses that set the interrupt flags |
| irq_pull_o | output | 1 | 1 = pull the open-drain interrupt line low, 0 = release it |

## Verification
The checks take the mode pins as fixed for the length of an access. They also assume the host holds address and data stable from before a strobe until the strobe and the select are both released, and keeps every strobe or latch pulse level for at least three clocks. In separate-strobe mode the host never asserts both strobes at once. The bench drives every bus phase at the falling clock edge and holds each phase for several clocks, which keeps it inside these limits. It changes a mode pin only while select and strobes are idle.

// File: rtl/dmhi_pkg.sv
package dmhi_pkg;

    typedef enum logic {
        STB_SPLIT = 1'b0,
        STB_QUAL  = 1'b1
    } strobe_mode_e;

    typedef struct packed {
        logic cs_n;
        logic line_a_n;
        logic line_b;
        logic ale;
    } bus_pins_t;

    localparam bus_pins_t PINS_IDLE = '{cs_n: 1'b1, line_a_n: 1'b1, line_b: 1'b1, ale: 1'b0};

    // Read: selected, line A low, line B high (same in both strobe modes).
    function automatic logic read_active(bus_pins_t p);
        return !p.cs_n && !p.line_a_n && p.line_b;
    endfunction

    // Write: split mode uses line B alone; qualifier mode needs data strobe too.
    function automatic logic write_active(strobe_mode_e mode, bus_pins_t p);
        return !p.cs_n && !p.line_b && ((mode == STB_SPLIT) || !p.line_a_n);
    endfunction

    function automatic logic fell(logic prev, logic now);
        return prev && !now;
    endfunction

endpackage

// File: rtl/dmhi_sync.sv
module dmhi_sync #(
    parameter int W = 1,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dmhi_decode.sv
module dmhi_decode
    import dmhi_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  strobe_mode_e mode,
    input  logic         mux_mode,
    input  bus_pins_t    pins_s,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic         wr_commit,
    output logic [AW-1:0] acc_addr,
    output logic [DW-1:0] wr_data,
    output logic         ale_fall
);
    logic          wr_now;
    logic          wr_q;
    logic          ale_q;
    logic [AW-1:0] addr_latch_q;

    always_comb wr_now = write_active(mode, pins_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q         <= 1'b0;
            ale_q        <= 1'b0;
            addr_latch_q <= '0;
        end else begin
            wr_q  <= wr_now;
            ale_q <= pins_s.ale;
            if (ale_fall) begin
                addr_latch_q <= data_s[AW-1:0];
            end
        end
    end

    assign ale_fall  = fell(ale_q, pins_s.ale);
    assign wr_commit = fell(wr_q, wr_now);
    assign acc_addr  = mux_mode ? addr_latch_q : addr_s;
    assign wr_data   = data_s;
endmodule

// File: rtl/dmhi_regs.sv
module dmhi_regs #(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int NREG = 8,
    parameter int NEV = 8,
    parameter int RST_BASE = 'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_commit,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NEV-1:0] evt_i,
    output logic [DW-1:0] rd_data_q,
    output logic          irq_q
);
    localparam logic [AW-1:0] FLAG_A = AW'(NREG);
    localparam logic [AW-1:0] MASK_A = AW'(NREG + 1);

    logic [NREG-1:0][DW-1:0] gen_q;
    logic [NEV-1:0] flag_q;
    logic [NEV-1:0] mask_q;
    logic [NEV-1:0] clr;
    logic [DW-1:0]  rd_next;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= DW'(RST_BASE + i);
            end else if (wr_commit && acc_addr == AW'(i)) begin
                q <= wr_data;
            end
        end
        assign gen_q[i] = q;
    end

    assign clr = (wr_commit && acc_addr == FLAG_A) ? wr_data[NEV-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            flag_q <= (flag_q & ~clr) | evt_i;
            if (wr_commit && acc_addr == MASK_A) begin
                mask_q <= wr_data[NEV-1:0];
            end
            irq_q <= |(flag_q & mask_q);
        end
    end

    always_comb begin
        rd_next = '0;
        for (int i = 0; i < NREG; i++) begin
            if (acc_addr == AW'(i)) rd_next = gen_q[i];
        end
        if (acc_addr == FLAG_A) rd_next = DW'(flag_q);
        if (acc_addr == MASK_A) rd_next = DW'(mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_next;
    end
endmodule

// File: rtl/dualmode_host_if.sv
module dualmode_host_if
    import dmhi_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 8,
    parameter int NREG = 8,
    parameter int NEV = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RST_BASE = 'hA0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe_mode_i,
    input  logic           mux_mode_i,
    input  logic           cs_n_i,
    input  logic           ale_i,
    input  logic           line_a_n_i,
    input  logic           line_b_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [DW-1:0]  bus_d_i,
    output logic [DW-1:0]  bus_d_o,
    output logic           bus_d_oe_o,
    input  logic [NEV-1:0] evt_i,
    output logic           irq_pull_o
);
    localparam int PW = $bits(bus_pins_t);
    localparam int XW = AW + DW;

    strobe_mode_e  mode;
    bus_pins_t     pins_raw;
    bus_pins_t     pins_s;
    logic [XW-1:0] ad_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] data_s;
    logic          wr_commit;
    logic [AW-1:0] acc_addr;
    logic [DW-1:0] wr_data;
    logic          ale_fall;

    assign mode     = strobe_mode_e'(strobe_mode_i);
    assign pins_raw = '{cs_n: cs_n_i, line_a_n: line_a_n_i, line_b: line_b_i, ale: ale_i};

    dmhi_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_s)
    );

    dmhi_sync #(.W(XW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk(clk), .rst_n(rst_n), .d({addr_i, bus_d_i}), .q(ad_s)
    );

    assign addr_s = ad_s[XW-1:DW];
    assign data_s = ad_s[DW-1:0];

    dmhi_decode #(.AW(AW), .DW(DW)) u_decode (
        .clk(clk), .rst_n(rst_n), .mode(mode), .mux_mode(mux_mode_i),
        .pins_s(pins_s), .addr_s(addr_s), .data_s(data_s),
        .wr_commit(wr_commit), .acc_addr(acc_addr), .wr_data(wr_data), .ale_fall(ale_fall)
    );

    dmhi_regs #(.AW(AW), .DW(DW), .NREG(NREG), .NEV(NEV), .RST_BASE(RST_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_commit(wr_commit), .acc_addr(acc_addr),
        .wr_data(wr_data), .evt_i(evt_i), .rd_data_q(bus_d_o), .irq_q(irq_pull_o)
    );

    // Enable is taken from the raw pins so the bus is released with no delay.
    assign bus_d_oe_o = read_active(pins_raw);
endmodule

// File: rtl/dualmode_host_if_chk.sv
module dualmode_host_if_chk #(
    parameter int AW = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mux_mode_i,
    input logic          cs_n_i,
    input logic          line_b_i,
    input logic          bus_d_oe_o,
    input logic          irq_pull_o,
    input logic          wr_commit,
    input logic          ale_fall,
    input logic [AW-1:0] acc_addr
);
    localparam int LIM = SYNC_STAGES + 3;

    logic [3:0] sel_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            sel_age <= 4'hF;
        else if (!cs_n_i)      sel_age <= '0;
        else if (sel_age != 4'hF) sel_age <= sel_age + 4'd1;
    end

    a_r1_irq_released_in_reset: assert property (@(posedge clk)
        !rst_n |-> !irq_pull_o);

    a_r3_drive_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe_o |-> !cs_n_i);

    a_r7_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe_o |-> line_b_i);

    a_r6_commit_needs_recent_select: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> (int'(sel_age) <= LIM));

    a_r5_latched_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode_i && !ale_fall) |=> (!mux_mode_i || $stable(acc_addr)));
endmodule

bind dualmode_host_if dualmode_host_if_chk #(.AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk(clk), .rst_n(rst_n), .mux_mode_i(mux_mode_i), .cs_n_i(cs_n_i),
    .line_b_i(line_b_i), .bus_d_oe_o(bus_d_oe_o), .irq_pull_o(irq_pull_o),
    .wr_commit(wr_commit), .ale_fall(ale_fall), .acc_addr(acc_addr)
);

// File: tb/dualmode_host_if_tb_top.sv
module dualmode_host_if_tb_top;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int NEV = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           strobe_mode = 1'b0;
    logic           mux_mode = 1'b0;
    logic           cs_n = 1'b1;
    logic           ale = 1'b0;
    logic           line_a_n = 1'b1;
    logic           line_b = 1'b1;
    logic [AW-1:0]  addr = '0;
    logic [DW-1:0]  d_i = '0;
    logic [DW-1:0]  d_o;
    logic           d_oe;
    logic [NEV-1:0] evt = '0;
    logic           irq;

    dualmode_host_if dut_i (
        .clk(clk), .rst_n(rst_n), .strobe_mode_i(strobe_mode), .mux_mode_i(mux_mode),
        .cs_n_i(cs_n), .ale_i(ale), .line_a_n_i(line_a_n), .line_b_i(line_b),
        .addr_i(addr), .bus_d_i(d_i), .bus_d_o(d_o), .bus_d_oe_o(d_oe),
        .evt_i(evt), .irq_pull_o(irq)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct { string tag; logic [7:0] val; } exp_t;
    exp_t exp_q[$];
    event sample_ev;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares read data with the queued expectation.
    initial begin : monitor
        forever begin
            @(sample_ev);
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL scoreboard: actual %0h expected none", d_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, {24'h0, d_o}, {24'h0, e.val});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latch_addr(input logic [3:0] a);
        d_i = {4'h0, a};
        ale = 1'b1;
        tick(3);
        ale = 1'b0;
        tick(3);
    endtask

    task automatic do_write(input bit qual, input bit mux, input bit sel,
                            input logic [3:0] a, input logic [7:0] d, input string tag);
        strobe_mode = qual;
        mux_mode = mux;
        if (mux) latch_addr(a); else addr = a;
        d_i = d;
        cs_n = !sel;
        tick(2);
        line_b = 1'b0;
        if (qual) begin
            tick(1);
            line_a_n = 1'b0;
        end
        tick(3);
        chk({"R7 no drive during write: ", tag}, {31'h0, d_oe}, 32'h0);
        if (qual) line_a_n = 1'b1; else line_b = 1'b1;
        tick(4);
        line_b = 1'b1;
        cs_n = 1'b1;
        tick(2);
    endtask

    task automatic do_read(input bit qual, input bit mux, input bit latch,
                           input logic [3:0] a, input logic [7:0] exp, input string tag);
        strobe_mode = qual;
        mux_mode = mux;
        if (mux && latch) latch_addr(a); else if (!mux) addr = a;
        d_i = 8'hFF;
        cs_n = 1'b0;
        tick(1);
        line_b = 1'b1;
        line_a_n = 1'b0;
        tick(6);
        chk({"R3 bus driven: ", tag}, {31'h0, d_oe}, 32'h1);
        exp_q.push_back('{tag: tag, val: exp});
        -> sample_ev;
        #1;
        line_a_n = 1'b1;
        #1;
        chk({"R3 bus released: ", tag}, {31'h0, d_oe}, 32'h0);
        tick(1);
        cs_n = 1'b1;
        tick(2);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        tick(3);
        chk("R1 irq released in reset", {31'h0, irq}, 32'h0);
        chk("R1 bus idle in reset", {31'h0, d_oe}, 32'h0);
        rst_n = 1'b1;
        tick(2);

        // R1 reset values
        do_read(0, 0, 0, 4'h0, 8'hA0, "R1 reg0 default");
        do_read(0, 0, 0, 4'h3, 8'hA3, "R1 reg3 default");
        do_read(0, 0, 0, 4'h7, 8'hA7, "R1 reg7 default");
        do_read(0, 0, 0, 4'h8, 8'h00, "R1 flags default");
        do_read(0, 0, 0, 4'h9, 8'h00, "R1 mask default");

        // R2 split-strobe writes
        do_write(0, 0, 1, 4'h2, 8'h3C, "R2 reg2");
        do_read(0, 0, 0, 4'h2, 8'h3C, "R2 reg2 readback");
        do_write(0, 0, 1, 4'h5, 8'hC3, "R2 reg5");
        do_read(0, 0, 0, 4'h5, 8'hC3, "R2 reg5 readback");

        // R4 qualifier mode
        do_write(1, 0, 1, 4'h1, 8'h96, "R4 reg1");
        do_read(1, 0, 0, 4'h1, 8'h96, "R4 reg1 readback");
        do_read(1, 0, 0, 4'h2, 8'h3C, "R4 reg2 read in qualifier mode");

        // R5 multiplexed address, addr_i held at 0
        addr = 4'h0;
        do_write(0, 1, 1, 4'h6, 8'h5A, "R5 reg6 via latch");
        do_read(0, 1, 1, 4'h6, 8'h5A, "R5 reg6 read after new latch");
        do_read(0, 1, 0, 4'h6, 8'h5A, "R5 latched address held");
        do_write(1, 1, 1, 4'h4, 8'h11, "R5 reg4 muxed qualifier");
        do_read(0, 0, 0, 4'h4, 8'h11, "R5 reg4 readback split");

        // R6 deselected strobes
        do_write(0, 0, 0, 4'h2, 8'h00, "R6 write while deselected");
        do_read(0, 0, 0, 4'h2, 8'h3C, "R6 reg2 unchanged");
        strobe_mode = 1'b0;
        addr = 4'h2;
        line_a_n = 1'b0;
        tick(6);
        chk("R6 no drive while deselected", {31'h0, d_oe}, 32'h0);
        line_a_n = 1'b1;
        tick(2);

        // R9 unmapped
        do_write(0, 0, 1, 4'hC, 8'h77, "R9 write unmapped");
        do_read(0, 0, 0, 4'hC, 8'h00, "R9 unmapped reads zero");
        do_read(0, 0, 0, 4'hF, 8'h00, "R9 top address reads zero");

        // R8 interrupt
        do_write(0, 0, 1, 4'h9, 8'h05, "R8 mask write");
        do_read(0, 0, 0, 4'h9, 8'h05, "R8 mask readback");
        chk("R8 irq idle before event", {31'h0, irq}, 32'h0);
        evt = 8'h04;
        tick(1);
        evt = 8'h00;
        tick(3);
        chk("R8 irq on masked event", {31'h0, irq}, 32'h1);
        do_read(0, 0, 0, 4'h8, 8'h04, "R8 flag readback");
        do_write(0, 0, 1, 4'h8, 8'h04, "R8 flag clear");
        chk("R8 irq released after clear", {31'h0, irq}, 32'h0);
        do_read(0, 0, 0, 4'h8, 8'h00, "R8 flag cleared");
        evt = 8'h02;
        tick(1);
        evt = 8'h00;
        tick(3);
        chk("R8 irq stays released for unmasked flag", {31'h0, irq}, 32'h0);
        do_read(0, 0, 0, 4'h8, 8'h02, "R8 unmasked flag recorded");
        evt = 8'h01;
        tick(1);
        evt = 8'h00;
        tick(3);
        chk("R8 irq on second masked bit", {31'h0, irq}, 32'h1);

        // R1 reset during operation, no clock edge needed
        #2;
        rst_n = 1'b0;
        #1;
        chk("R1 irq released immediately by reset", {31'h0, irq}, 32'h0);
        tick(2);
        rst_n = 1'b1;
        tick(2);
        do_read(0, 0, 0, 4'h2, 8'hA2, "R1 reg2 back to default");
        do_read(0, 0, 0, 4'h9, 8'h00, "R1 mask back to default");
        do_read(0, 0, 0, 4'h8, 8'h00, "R1 flags back to default");

        tick(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule